// File: doc/BRIEF.md
# Serial Fuse Program Sequencer

This block burns one word of a one-time-programmable fuse array. A front-end hands it a word address and a 32-bit program pattern over a valid/ready request channel. The sequencer first reads the word already stored at that address and clears every request bit whose fuse is already blown, so that no fuse is ever strobed twice. It then walks the masked pattern serially, least significant bit first, shifting the working register right with zero fill once per bit. Each set bit gets a relax phase, a programming strobe and a second relax phase. Each clear bit is passed over in a single cycle.

All phase lengths come from a timing word sampled when the request is accepted. The program strobe count, the relax count and the read strobe count sit in fixed fields, and every count N gives a phase of N+1 cycles, so a zero relax field still gives a one-cycle phase. When the last bit is handled, BUSY falls and a one-cycle done pulse rises on the same edge. A postamble of fixed length then follows, during which no new request and no shadow-reload grant is issued. The fuse array is modelled inside the block as a register file with per-bit set strobes and a side read port for inspection.

The request channel follows valid/ready rules. The requester holds `req_valid`, `req_addr` and `req_data` until a cycle in which `req_ready` is high, and the transfer occurs on that edge. `req_ready` stays low for the whole operation and the postamble, so the requester sees back-pressure and nothing is queued.

Top module: `fuse_prog_seq`

## Requirements
- R1: `req_ready` is high only when the block is idle and `reload_req` is low. A request is accepted on an edge where `req_valid` and `req_ready` are both high, and `busy` is high from the next cycle on.
- R2: Before programming, the request is ANDed with the inverse of the stored word. `strobe` is high for exactly popcount(data & ~stored) × (P+1) cycles, so bits already at 1 get no strobe.
- R3: After the operation, the addressed word equals the old value OR the request. Every other word is unchanged, and no fuse bit ever returns to 0.
- R4: The working register `prog_data` shifts right with zero fill once per bit, LSB first. It does not change during a strobe, and it reads 0 when done is pulsed. Changes on `req_data` after acceptance have no effect.
- R5: Timing fields are P = `timing_cfg[11:0]` (program strobe), R = `timing_cfg[15:12]` (relax) and S = `timing_cfg[21:16]` (read strobe). All other bits are ignored. With k bits left after masking, `busy` lasts exactly (S+1) + 32 + k×(2R+P+3) cycles.
- R6: A relax count of 0 still gives a one-cycle relax phase before and after each strobe.
- R7: A bit that is 0 after masking takes one cycle and no strobe. A fully masked request keeps `busy` high for S+33 cycles.
- R8: `done` is high for exactly one cycle, on the same edge at which `busy` falls.
- R9: `quiet` (postamble) is high for exactly POST_CYC cycles, starting with the done cycle. `req_ready` and `reload_go` are low throughout.
- R10: `reload_go` equals `reload_req` while idle and is low otherwise, so a reload request made during an operation or the postamble is held until idle. Reload takes priority over a pending program request.
- R11: After reset the block is idle: `req_ready` is 1, `busy`, `done`, `quiet` and `strobe` are 0, and every fuse word reads 0.
- R12: The timing word is captured at acceptance. Changing `timing_cfg` during an operation does not change its duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Program request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | AW | Fuse word address |
| req_data | input | W | Bits to blow (1 = blow) |
| timing_cfg | input | 32 | Timing word: P[11:0], R[15:12], S[21:16] |
| reload_req | input | 1 | Shadow reload wanted |
| reload_go | output | 1 | Reload may proceed this cycle |
| busy | output | 1 | Program operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quiet | output | 1 | Postamble in progress |
| strobe | output | 1 | Program strobe active |
| prog_data | output | W | Working shift register |
| peek_addr | input | AW | Fuse array inspection address |
| peek_data | output | W | Fuse word at peek_addr |

## Verification
The bench targets several corner cases:
- Re-programming a word that already has blown bits. A design that skipped the pre-read mask would strobe those bits again, and the strobe count would come out too high.
- A zero relax field. An off-by-one in the phase counter would give zero-length phases there, and the busy length would come out short.
- A fully masked request, which must cost one cycle per bit. A design that strobed clear bits would run long.
- Changes to the timing word and the request data after acceptance. These show whether live inputs leak into a running operation.
- A reload request raised mid-operation, which exposes a grant that is not held back through busy and the postamble.
- Simultaneous reload and program requests in idle, which exposes a wrong priority.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  localparam int PROG_W  = 12;
  localparam int RELAX_W = 4;
  localparam int RSTB_W  = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDS, ST_EVAL, ST_SETUP, ST_STRB, ST_HOLD, ST_POST
  } seq_state_e;

  typedef struct packed {
    logic [RSTB_W-1:0]  rstb;
    logic [RELAX_W-1:0] relax;
    logic [PROG_W-1:0]  prog;
  } fuse_timing_t;

  function automatic fuse_timing_t unpack_timing(input logic [31:0] raw);
    fuse_timing_t t;
    t.prog  = raw[11:0];
    t.relax = raw[15:12];
    t.rstb  = raw[21:16];
    return t;
  endfunction
endpackage

// File: rtl/fuse_cell_array.sv
module fuse_cell_array #(
  parameter int W     = 32,
  parameter int WORDS = 8,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [W-1:0]  set_mask,
  input  logic [AW-1:0] rd_a_addr,
  output logic [W-1:0]  rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [W-1:0]  rd_b_data
);
  logic [W-1:0] cells [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cells[g] <= '0;
      else if (set_en && (set_addr == AW'(g))) cells[g] <= cells[g] | set_mask;
    end
  end

  assign rd_a_data = cells[rd_a_addr];
  assign rd_b_data = cells[rd_b_addr];
endmodule

// File: rtl/fuse_phase_timer.sv
module fuse_phase_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/fuse_prog_fsm.sv
module fuse_prog_fsm
  import fuse_seq_pkg::*;
#(
  parameter int W        = 32,
  parameter int AW       = 3,
  parameter int POST_CYC = 200,
  localparam int BW      = (W > 1) ? $clog2(W) : 1,
  localparam int PCW     = $clog2(POST_CYC + 1),
  localparam int CW      = (PCW > PROG_W) ? PCW : PROG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_data,
  input  logic [31:0]   timing_cfg,
  input  logic          reload_req,
  input  logic [W-1:0]  rd_word,
  output logic [AW-1:0] op_addr,
  output logic          set_en,
  output logic [W-1:0]  set_mask,
  output logic          req_ready,
  output logic          reload_go,
  output logic          busy,
  output logic          done,
  output logic          quiet,
  output logic          strobe,
  output logic [W-1:0]  prog_data
);
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  seq_state_e   state_q, state_d;
  logic [W-1:0] data_q, data_d;
  logic [BW-1:0] bidx_q, bidx_d;
  logic [AW-1:0] addr_q, addr_d;
  fuse_timing_t tim_q, tim_d;
  fuse_timing_t tim_in;
  logic         done_q, done_d;
  logic         ld, expired, adv;
  logic [CW-1:0] ldv;

  fuse_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ldv), .expired(expired)
  );

  assign tim_in = unpack_timing(timing_cfg);

  always_comb begin
    state_d = state_q;
    data_d  = data_q;
    bidx_d  = bidx_q;
    addr_d  = addr_q;
    tim_d   = tim_q;
    done_d  = 1'b0;
    ld      = 1'b0;
    ldv     = '0;
    set_en  = 1'b0;
    adv     = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid && req_ready) begin
        addr_d  = req_addr;
        data_d  = req_data;
        tim_d   = tim_in;
        ld      = 1'b1;
        ldv     = CW'(tim_in.rstb);
        state_d = ST_RDS;
      end
      ST_RDS: if (expired) begin
        data_d  = data_q & ~rd_word;
        bidx_d  = '0;
        state_d = ST_EVAL;
      end
      ST_EVAL: if (data_q[0]) begin
        ld      = 1'b1;
        ldv     = CW'(tim_q.relax);
        state_d = ST_SETUP;
      end else begin
        adv = 1'b1;
      end
      ST_SETUP: if (expired) begin
        ld      = 1'b1;
        ldv     = CW'(tim_q.prog);
        state_d = ST_STRB;
      end
      ST_STRB: if (expired) begin
        set_en  = 1'b1;
        ld      = 1'b1;
        ldv     = CW'(tim_q.relax);
        state_d = ST_HOLD;
      end
      ST_HOLD: if (expired) adv = 1'b1;
      ST_POST: if (expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (adv) begin
      data_d = data_q >> 1;
      bidx_d = bidx_q + 1'b1;
      if (bidx_q == LAST_BIT) begin
        state_d = ST_POST;
        done_d  = 1'b1;
        ld      = 1'b1;
        ldv     = CW'(POST_CYC - 1);
      end else begin
        state_d = ST_EVAL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      bidx_q  <= '0;
      addr_q  <= '0;
      tim_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      data_q  <= data_d;
      bidx_q  <= bidx_d;
      addr_q  <= addr_d;
      tim_q   <= tim_d;
      done_q  <= done_d;
    end
  end

  assign op_addr   = addr_q;
  assign set_mask  = W'(1) << bidx_q;
  assign req_ready = (state_q == ST_IDLE) && !reload_req;
  assign reload_go = (state_q == ST_IDLE) && reload_req;
  assign busy      = (state_q != ST_IDLE) && (state_q != ST_POST);
  assign quiet     = (state_q == ST_POST);
  assign strobe    = (state_q == ST_STRB);
  assign done      = done_q;
  assign prog_data = data_q;
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq #(
  parameter int W        = 32,
  parameter int WORDS    = 8,
  parameter int POST_CYC = 200,
  localparam int AW      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_data,
  input  logic [31:0]   timing_cfg,
  input  logic          reload_req,
  output logic          reload_go,
  output logic          busy,
  output logic          done,
  output logic          quiet,
  output logic          strobe,
  output logic [W-1:0]  prog_data,
  input  logic [AW-1:0] peek_addr,
  output logic [W-1:0]  peek_data
);
  logic [AW-1:0] op_addr;
  logic [W-1:0]  rd_word, set_mask;
  logic          set_en;

  fuse_cell_array #(.W(W), .WORDS(WORDS)) u_array (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_addr(op_addr), .set_mask(set_mask),
    .rd_a_addr(op_addr), .rd_a_data(rd_word),
    .rd_b_addr(peek_addr), .rd_b_data(peek_data)
  );

  fuse_prog_fsm #(.W(W), .AW(AW), .POST_CYC(POST_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .timing_cfg(timing_cfg), .reload_req(reload_req), .rd_word(rd_word),
    .op_addr(op_addr), .set_en(set_en), .set_mask(set_mask),
    .req_ready(req_ready), .reload_go(reload_go), .busy(busy), .done(done),
    .quiet(quiet), .strobe(strobe), .prog_data(prog_data)
  );
endmodule

// File: rtl/fuse_prog_seq_chk.sv
module fuse_prog_seq_chk #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          reload_go,
  input logic          busy,
  input logic          done,
  input logic          quiet,
  input logic          strobe,
  input logic [W-1:0]  prog_data,
  input logic [AW-1:0] peek_addr,
  input logic [W-1:0]  peek_data
);
  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && !quiet));
  a_r2_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> busy);
  a_r3_fuse_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(peek_addr) |-> ((peek_data & $past(peek_data)) == $past(peek_data)));
  a_r4_empty_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prog_data == '0));
  a_r4_frozen_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |-> $stable(prog_data));
  a_r8_done_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_quiet_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (quiet && done));
  a_r10_reload_gated: assert property (@(posedge clk) disable iff (!rst_n)
    reload_go |-> (!busy && !quiet && !req_ready));
endmodule

bind fuse_prog_seq fuse_prog_seq_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .reload_go(reload_go),
  .busy(busy), .done(done), .quiet(quiet), .strobe(strobe),
  .prog_data(prog_data), .peek_addr(peek_addr), .peek_data(peek_data)
);

// File: tb/test_fuse_prog_seq.sv
module test_fuse_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 32;
  localparam int WORDS = 8;
  localparam int AW    = 3;
  localparam int POST  = 24;
  localparam int NV    = 6;

  localparam int          V_ADDR [NV] = '{0, 0, 3, 5, 3, 7};
  localparam logic [31:0] V_DATA [NV] = '{32'h0000_0001, 32'h0000_0003, 32'h8000_0000,
                                          32'hA5A5_0F0F, 32'h8000_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] V_TIM  [NV] = '{32'h0002_1003, 32'h0002_1003, 32'h0000_0005,
                                          32'hFFC2_2004, 32'h0001_3002, 32'h003F_0000};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, reload_req = 0;
  logic [AW-1:0] req_addr = '0, peek_addr = '0;
  logic [W-1:0]  req_data = '0;
  logic [31:0]   timing_cfg = '0;
  logic req_ready, reload_go, busy, done, quiet, strobe;
  logic [W-1:0] prog_data, peek_data;
  logic [W-1:0] model [WORDS];
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_prog_seq #(.W(W), .WORDS(WORDS), .POST_CYC(POST)) i_fuse_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .timing_cfg(timing_cfg),
    .reload_req(reload_req), .reload_go(reload_go), .busy(busy), .done(done),
    .quiet(quiet), .strobe(strobe), .prog_data(prog_data),
    .peek_addr(peek_addr), .peek_data(peek_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_array(input string req);
    for (int i = 0; i < WORDS; i++) begin
      peek_addr = AW'(i);
      #1;
      check(peek_data == model[i], req, $sformatf("word %0d", i), peek_data, model[i]);
    end
  endtask

  task automatic run_op(input int a, input logic [31:0] d, input logic [31:0] t,
                        input logic [31:0] t_after, input bit rl);
    int p, r, s, k, exp_busy, exp_strb, bc, sc, qc, dc, guard;
    bit leak;
    p = int'(t[11:0]); r = int'(t[15:12]); s = int'(t[21:16]);
    k = $countones(d & ~model[a]);
    exp_busy = s + 1 + W + k * (2*r + p + 3);
    exp_strb = k * (p + 1);
    @(negedge clk);
    req_addr = AW'(a); req_data = d; timing_cfg = t; req_valid = 1;
    check(req_ready == 1, "R1", "ready in idle", req_ready, 1);
    @(negedge clk);
    req_valid = 0; req_data = ~d; timing_cfg = t_after; reload_req = rl;
    check(busy == 1, "R1", "busy after accept", busy, 1);
    bc = 0; sc = 0; qc = 0; dc = 0; guard = 0; leak = 0;
    while (busy && guard < 50000) begin
      bc++;
      if (strobe) sc++;
      if (req_ready || reload_go || done) leak = 1;
      @(negedge clk); guard++;
    end
    check(done == 1, "R8", "done as busy falls", done, 1);
    check(prog_data == '0, "R4", "data empty at done", prog_data, 0);
    check(bc == exp_busy, "R5", "busy length", bc, exp_busy);
    check(sc == exp_strb, "R2", "strobe cycles", sc, exp_strb);
    while (quiet && guard < 50000) begin
      qc++;
      if (done) dc++;
      if (req_ready || reload_go) leak = 1;
      @(negedge clk); guard++;
    end
    check(dc == 1, "R8", "done pulse width", dc, 1);
    check(qc == POST, "R9", "postamble length", qc, POST);
    check(!leak, "R10", "no ready/grant while busy or quiet", leak, 0);
    if (rl) begin
      check(reload_go == 1, "R10", "held reload granted at idle", reload_go, 1);
      check(req_ready == 0, "R10", "reload blocks request", req_ready, 0);
      reload_req = 0;
    end
    model[a] = model[a] | d;
    check_array("R3");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(req_ready == 1, "R11", "ready", req_ready, 1);
    check(busy == 0 && done == 0 && quiet == 0 && strobe == 0, "R11", "idle flags",
          {busy, done, quiet, strobe}, 0);
    rst_n = 1;
    @(negedge clk);
    check_array("R11");

    // vector table: R2 remask (v1), R6 relax 0 (v2), R5 reserved bits (v3), R7 fully masked (v4)
    for (int v = 0; v < NV; v++) run_op(V_ADDR[v], V_DATA[v], V_TIM[v], V_TIM[v], 0);

    // R12 timing changed mid-operation; R10 reload raised during operation
    run_op(6, 32'h0000_00F0, 32'h0003_2006, 32'h003F_FFFF, 1);

    // R10 priority: reload and request together in idle
    @(negedge clk);
    reload_req = 1; req_valid = 1; req_addr = 3'd1; req_data = 32'h1; timing_cfg = 32'h0;
    #1;
    check(req_ready == 0, "R10", "ready blocked by reload", req_ready, 0);
    check(reload_go == 1, "R10", "reload granted", reload_go, 1);
    @(negedge clk);
    check(busy == 0, "R10", "no op started", busy, 0);
    reload_req = 0; req_valid = 0;
    check_array("R10");

    // R7 zero request: no strobe, S+33 busy
    run_op(2, 32'h0, 32'h0005_1001, 32'h0005_1001, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule